// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Register Port

This block is a 16-bit counter reached through a small byte-wide register port. One control byte picks its job: a pulse-width generator whose high and low times come from two separate 16-bit limit registers, a free-running counter that snapshots its value when an edge arrives on one of two capture inputs, or an event counter that advances on edges of an external input. A second control byte holds the event flags and the interrupt enables. The count always passes through a power-of-two prescaler first.

Software programs the limit registers and the mode byte, then writes the clear-timer address to start from zero in a known phase. Capture results are read back as byte pairs. Flags stay set until software rewrites the flag byte, and three interrupt request lines follow each flag gated by its enable bit. The register port has no handshake: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `ptimer16`

## Requirements
- R1: After reset the count is zero, every readable address returns 0x00, `pwm_out` is low and all three interrupt lines are low.
- R2: Reads: 0x00/0x01 capture low/high, 0x02/0x03 limit-B low/high, 0x04/0x05 limit-A low/high, 0x06 mode byte, 0x07 flag byte. Writes: 0x12/0x13 limit-B, 0x14/0x15 limit-A, 0x16 mode byte, 0x17 flag byte.
- R3: A write to address 0x10 sets the count and the prescaler to zero and puts the pulse generator in its high phase, whatever the data byte holds.
- R4: Mode byte bits 1:0 pick the job (00 stopped, 01 pulse generator, 10 capture/compare, 11 event counter); while stopped the count holds, and `pwm_out` is low in every mode but 01.
- R5: Mode byte bits 4:2 hold N; the count advances once per 2^N source pulses, a source pulse being every clock in modes 01 and 10 and each detected rising edge of `evt_in` in mode 11.
- R6: In mode 01, starting from a clear, `pwm_out` is high for max(limit-A,1) count steps, then low for max(limit-B,1) steps, repeating, and the count restarts at zero at each phase change.
- R7: Flag bit 4 is set at the step that ends a low phase in mode 01, and in modes 10 and 11 at a step taken while the count equals limit-B.
- R8: Capture inputs pass a two-flop synchronizer and edge detector; mode byte bit 6 picks the edge (1 rising, 0 falling). In mode 10 an edge on `cap1_in` copies the count into the capture register and sets flag bit 6, three clocks after the input changes; other edges are ignored.
- R9: In mode 10 a selected edge on `cap2_in` copies the count into limit-B and sets flag bit 7; it wins over a software write to limit-B in the same clock.
- R10: In mode 11 the count advances on rising edges of `evt_in` after synchronization, so the compare flag appears on the edge that finds the count equal to limit-B.
- R11: A write to the flag byte stores the data (writing zero clears all flags); a flag set by hardware in the same clock stays set.
- R12: `cap_irq` is (flag 6 or flag 7) and enable bit 5, `cmp_irq` is flag 4 and enable bit 2, and `irq` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| evt_in | input | 1 | External event input |
| cap1_in | input | 1 | Capture input to the capture register |
| cap2_in | input | 1 | Capture input to limit-B |
| pwm_out | output | 1 | Pulse generator output |
| cap_irq | output | 1 | Capture interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: a 16-bit count, a 3-bit prescale select and two synchronizer stages. With those values short limit pairs (0/0, 3/2 and 2/1 at N=1) give whole pulse periods inside a dozen clocks, so every cycle of several periods is compared. The fixed three-clock capture latency lets exact capture values be predicted from the clear edge, including a capture that collides with a software write to limit-B.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_PWM    = 2'b01,
    MODE_CAPCMP = 2'b10,
    MODE_EVENT  = 2'b11
  } tmr_mode_e;

  localparam int ADDR_W = 5;

  // read side
  localparam logic [ADDR_W-1:0] A_RD_CAP_LO = 5'h00;
  localparam logic [ADDR_W-1:0] A_RD_CAP_HI = 5'h01;
  localparam logic [ADDR_W-1:0] A_RD_LB_LO  = 5'h02;
  localparam logic [ADDR_W-1:0] A_RD_LB_HI  = 5'h03;
  localparam logic [ADDR_W-1:0] A_RD_LA_LO  = 5'h04;
  localparam logic [ADDR_W-1:0] A_RD_LA_HI  = 5'h05;
  localparam logic [ADDR_W-1:0] A_RD_MODE   = 5'h06;
  localparam logic [ADDR_W-1:0] A_RD_FLAG   = 5'h07;

  // write side
  localparam logic [ADDR_W-1:0] A_WR_CLEAR  = 5'h10;
  localparam logic [ADDR_W-1:0] A_WR_LB_LO  = 5'h12;
  localparam logic [ADDR_W-1:0] A_WR_LB_HI  = 5'h13;
  localparam logic [ADDR_W-1:0] A_WR_LA_LO  = 5'h14;
  localparam logic [ADDR_W-1:0] A_WR_LA_HI  = 5'h15;
  localparam logic [ADDR_W-1:0] A_WR_MODE   = 5'h16;
  localparam logic [ADDR_W-1:0] A_WR_FLAG   = 5'h17;

  // flag byte fields
  localparam int FB_CMP_EN  = 2;
  localparam int FB_CMP     = 4;
  localparam int FB_CAP_EN  = 5;
  localparam int FB_CAP1    = 6;
  localparam int FB_CAP2    = 7;

  // mode byte fields
  localparam int MB_PS_LSB  = 2;
  localparam int MB_EDGE    = 6;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign edge_o = rise_sel ? (chain[STAGES-1] & ~prev)
                           : (~chain[STAGES-1] & prev);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             src_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] mask;

  always_comb mask = ~({DIV_W{1'b1}} << sel);

  assign tick = src_pulse && ((pc & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc <= '0;
    else if (restart)   pc <= '0;
    else if (src_pulse) pc <= pc + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim_a,
  input  logic [CNT_W-1:0] lim_b,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_hi,
  output logic             cmp_hit
);
  logic [CNT_W-1:0] last_a, last_b;
  logic             end_hi, end_lo;

  always_comb begin
    last_a = (lim_a == '0) ? '0 : lim_a - 1'b1;
    last_b = (lim_b == '0) ? '0 : lim_b - 1'b1;
    end_hi = phase_hi  && (cnt >= last_a);
    end_lo = !phase_hi && (cnt >= last_b);
  end

  always_comb begin
    cmp_hit = 1'b0;
    if (tick) begin
      case (mode)
        MODE_PWM:               cmp_hit = end_lo;
        MODE_CAPCMP, MODE_EVENT: cmp_hit = (cnt == lim_b);
        default:                cmp_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (clear) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
    end else if (tick) begin
      case (mode)
        MODE_PWM: begin
          if (end_hi || end_lo) begin
            cnt      <= '0;
            phase_hi <= !phase_hi;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        MODE_CAPCMP, MODE_EVENT: cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ptimer16.sv
module ptimer16
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int PS_SEL_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        evt_in,
  input  logic        cap1_in,
  input  logic        cap2_in,
  output logic        pwm_out,
  output logic        cap_irq,
  output logic        cmp_irq,
  output logic        irq
);
  localparam int HI_LSB = DATA_W;

  logic [DATA_W-1:0] ctl_a, ctl_b;
  logic [CNT_W-1:0]  lim_a, lim_b, cap_q, cnt;
  tmr_mode_e         mode_sel;
  logic              clr_wr, tick, src_pulse, restart;
  logic              cap1_edge, cap2_edge, evt_edge;
  logic              cap1_hit, cap2_hit, cmp_hit, phase_hi;
  logic [PS_SEL_W-1:0] ps_sel;

  assign mode_sel = tmr_mode_e'(ctl_b[1:0]);
  assign ps_sel   = ctl_b[MB_PS_LSB +: PS_SEL_W];
  assign clr_wr   = reg_wr && (reg_addr == A_WR_CLEAR);

  // input conditioning
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_c1 (
    .clk(clk), .rst_n(rst_n), .din(cap1_in),
    .rise_sel(ctl_b[MB_EDGE]), .edge_o(cap1_edge));
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_c2 (
    .clk(clk), .rst_n(rst_n), .din(cap2_in),
    .rise_sel(ctl_b[MB_EDGE]), .edge_o(cap2_edge));
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ev (
    .clk(clk), .rst_n(rst_n), .din(evt_in),
    .rise_sel(1'b1), .edge_o(evt_edge));

  // prescaler
  always_comb begin
    case (mode_sel)
      MODE_OFF:   src_pulse = 1'b0;
      MODE_EVENT: src_pulse = evt_edge;
      default:    src_pulse = 1'b1;
    endcase
  end
  assign restart = clr_wr || (mode_sel == MODE_OFF);

  tmr_prescale #(.SEL_W(PS_SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .src_pulse(src_pulse), .sel(ps_sel), .tick(tick));

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clr_wr), .mode(mode_sel),
    .tick(tick), .lim_a(lim_a), .lim_b(lim_b),
    .cnt(cnt), .phase_hi(phase_hi), .cmp_hit(cmp_hit));

  assign cap1_hit = (mode_sel == MODE_CAPCMP) && cap1_edge;
  assign cap2_hit = (mode_sel == MODE_CAPCMP) && cap2_edge;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_b <= '0;
      lim_a <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_WR_MODE:  ctl_b <= reg_wdata;
        A_WR_LA_LO: lim_a[DATA_W-1:0]      <= reg_wdata;
        A_WR_LA_HI: lim_a[CNT_W-1:HI_LSB]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_b <= '0;
    end else if (cap2_hit) begin
      lim_b <= cnt;
    end else if (reg_wr && reg_addr == A_WR_LB_LO) begin
      lim_b[DATA_W-1:0] <= reg_wdata;
    end else if (reg_wr && reg_addr == A_WR_LB_HI) begin
      lim_b[CNT_W-1:HI_LSB] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (cap1_hit) cap_q <= cnt;
  end

  logic [DATA_W-1:0] ctl_a_nx;
  always_comb begin
    ctl_a_nx = (reg_wr && reg_addr == A_WR_FLAG) ? reg_wdata : ctl_a;
    if (cmp_hit)  ctl_a_nx[FB_CMP]  = 1'b1;
    if (cap1_hit) ctl_a_nx[FB_CAP1] = 1'b1;
    if (cap2_hit) ctl_a_nx[FB_CAP2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_a <= '0;
    else        ctl_a <= ctl_a_nx;
  end

  // read mux
  always_comb begin
    case (reg_addr)
      A_RD_CAP_LO: reg_rdata = cap_q[DATA_W-1:0];
      A_RD_CAP_HI: reg_rdata = cap_q[CNT_W-1:HI_LSB];
      A_RD_LB_LO:  reg_rdata = lim_b[DATA_W-1:0];
      A_RD_LB_HI:  reg_rdata = lim_b[CNT_W-1:HI_LSB];
      A_RD_LA_LO:  reg_rdata = lim_a[DATA_W-1:0];
      A_RD_LA_HI:  reg_rdata = lim_a[CNT_W-1:HI_LSB];
      A_RD_MODE:   reg_rdata = ctl_b;
      A_RD_FLAG:   reg_rdata = ctl_a;
      default:     reg_rdata = '0;
    endcase
  end

  assign pwm_out = (mode_sel == MODE_PWM) && phase_hi;
  assign cap_irq = (ctl_a[FB_CAP1] | ctl_a[FB_CAP2]) & ctl_a[FB_CAP_EN];
  assign cmp_irq = ctl_a[FB_CMP] & ctl_a[FB_CMP_EN];
  assign irq     = cap_irq | cmp_irq;
endmodule

// File: rtl/ptimer16_chk.sv
module ptimer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             clr_wr,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_out,
  input logic             cap1_hit,
  input logic [CNT_W-1:0] cap_q,
  input logic             flag_cap1
);
  // R3: clear write zeroes the count at the next edge
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0));

  // R4: stopped mode holds the count
  assert_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !clr_wr) |=> $stable(cnt));

  // R5: without a prescaled step the count does not move
  assert_no_tick_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_wr) |=> $stable(cnt));

  // R5: a step in a counting mode adds one
  assert_step_adds_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_wr && mode[1]) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R6: a phase change of the pulse output restarts the count
  assert_phase_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && pwm_out != $past(pwm_out))
      |-> (cnt == '0));

  // R8: a capture-1 edge stores the count and raises its flag
  assert_cap1_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap1_hit |=> (cap_q == $past(cnt) && flag_cap1));
endmodule

bind ptimer16 ptimer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(ctl_b[1:0]), .clr_wr(clr_wr),
  .tick(tick), .cnt(cnt), .pwm_out(pwm_out), .cap1_hit(cap1_hit),
  .cap_q(cap_q), .flag_cap1(ctl_a[6]));

// File: tb/ptimer16_test.sv
`timescale 1ns/1ps
module ptimer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_in = 1'b0, cap1_in = 1'b0, cap2_in = 1'b0;
  logic       pwm_out, cap_irq, cmp_irq, irq;

  always #2.5 clk = ~clk;

  ptimer16 uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .cap1_in(cap1_in), .cap2_in(cap2_in), .pwm_out(pwm_out),
    .cap_irq(cap_irq), .cmp_irq(cmp_irq), .irq(irq));

  typedef struct {
    int          kind;   // 0 read data, 1 pwm, 2 irq triple
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compares every queued expectation mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {8'h00, reg_rdata};
        1: act = {15'd0, pwm_out};
        default: act = {13'd0, irq, cap_irq, cmp_irq};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic push(input int k, input logic [15:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [7:0] e, input string t);
    reg_addr = a;
    push(0, {8'h00, e}, t);
    step();
  endtask

  task automatic chk_pwm_run(input int hi, input int lo, input int cycles, input string t);
    for (int k = 0; k < cycles; k++) begin
      push(1, ((k % (hi + lo)) < hi) ? 16'd1 : 16'd0, t);
      step();
    end
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    push(2, {13'd0, e}, t);
    step();
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt_in = 1'b1;
    repeat (2) @(negedge clk);
    evt_in = 1'b0;
    repeat (2) @(negedge clk);
    step();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 8; a++) chk_rd(5'(a), 8'h00, "R1 reset read");
    push(1, 16'd0, "R1 pwm after reset"); step();
    chk_irq(3'b000, "R1 irq after reset");

    // R2 register map
    wr(5'h14, 8'h34); wr(5'h15, 8'h12);
    wr(5'h12, 8'h78); wr(5'h13, 8'h56);
    wr(5'h16, 8'h80);
    chk_rd(5'h04, 8'h34, "R2 limit-A low");
    chk_rd(5'h05, 8'h12, "R2 limit-A high");
    chk_rd(5'h02, 8'h78, "R2 limit-B low");
    chk_rd(5'h03, 8'h56, "R2 limit-B high");
    chk_rd(5'h06, 8'h80, "R2 mode byte");
    wr(5'h16, 8'h00);

    // R6 pulse generator 3/2
    wr(5'h14, 8'h03); wr(5'h15, 8'h00);
    wr(5'h12, 8'h02); wr(5'h13, 8'h00);
    wr(5'h17, 8'h00);
    wr(5'h16, 8'h01);
    wr(5'h10, 8'hFF);                      // R3 clear with arbitrary data
    chk_pwm_run(3, 2, 10, "R6 R3 pwm 3/2");
    chk_rd(5'h07, 8'h10, "R7 compare flag after low phase");

    // R6 zero limits behave as one
    wr(5'h14, 8'h00); wr(5'h12, 8'h00);
    wr(5'h10, 8'h00);
    chk_pwm_run(1, 1, 6, "R6 pwm 0/0");

    // R5 prescale N=1, limits 2/1
    wr(5'h14, 8'h02); wr(5'h12, 8'h01);
    wr(5'h16, 8'h05);
    wr(5'h10, 8'h00);
    chk_pwm_run(4, 2, 12, "R5 pwm prescale 2");

    // R4 stopped mode forces output low
    wr(5'h10, 8'h00);
    push(1, 16'd1, "R4 pwm high before stop"); step();
    wr(5'h16, 8'h00);
    push(1, 16'd0, "R4 pwm low when stopped"); step();

    // R8 capture 1 rising
    wr(5'h12, 8'h01); wr(5'h13, 8'hFF);
    wr(5'h17, 8'h00);
    wr(5'h16, 8'h42);
    wr(5'h10, 8'h00);
    @(negedge clk); cap1_in = 1'b1;        // j=0 -> capture value 2
    repeat (4) step();
    chk_rd(5'h00, 8'h02, "R8 capture low");
    chk_rd(5'h01, 8'h00, "R8 capture high");
    chk_rd(5'h07, 8'h40, "R8 capture flag");
    @(negedge clk); cap1_in = 1'b0;        // falling ignored
    repeat (5) step();
    chk_rd(5'h00, 8'h02, "R8 wrong edge ignored");

    // R9 capture 2 falling, collides with a software write
    wr(5'h17, 8'h00);
    wr(5'h16, 8'h02);
    wr(5'h10, 8'h00);
    @(negedge clk); cap2_in = 1'b1;        // rising ignored
    repeat (5) @(negedge clk);
    cap2_in = 1'b0;                        // j=5 -> capture value 7
    repeat (2) @(negedge clk);
    reg_addr = 5'h12; reg_wdata = 8'hAA; reg_wr = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0;
    chk_rd(5'h02, 8'h07, "R9 capture into limit-B wins");
    chk_rd(5'h03, 8'h00, "R9 limit-B high");
    chk_rd(5'h07, 8'h80, "R9 capture-2 flag");

    // R11 flag byte writes
    wr(5'h17, 8'h00);
    chk_rd(5'h07, 8'h00, "R11 zero write clears");
    wr(5'h17, 8'h24);
    chk_rd(5'h07, 8'h24, "R11 stores data");

    // R12 interrupts
    wr(5'h17, 8'h20);
    wr(5'h16, 8'h42);
    @(negedge clk); cap1_in = 1'b1;
    repeat (4) step();
    chk_irq(3'b110, "R12 capture irq");
    wr(5'h17, 8'h24);
    chk_irq(3'b000, "R12 irq cleared");
    wr(5'h17, 8'h14);
    chk_irq(3'b101, "R12 compare irq");
    cap1_in = 1'b0;

    // R10 event counting
    wr(5'h16, 8'h00);
    wr(5'h12, 8'h03); wr(5'h13, 8'h00);
    wr(5'h16, 8'h03);
    wr(5'h17, 8'h00);
    wr(5'h10, 8'h00);
    repeat (3) pulse_evt();
    chk_rd(5'h07, 8'h00, "R10 no match after three events");
    pulse_evt();
    chk_rd(5'h07, 8'h10, "R10 match on fourth event");

    @(negedge clk); #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule